// File: doc/BRIEF.md
# PLL Cycle-Slip Unlock Detector

This block watches single-cycle cycle-slip pulses from a PLL phase detector. It counts the slips it accepts, and once the count reaches a programmable limit it pulls a lock-detect flag low. An 8-bit configuration register controls its behaviour. The register selects the slip limit, holds the slip counter in a cleared state, and sets how slips near a transmit-key event are handled.

A rising edge on the asynchronous key input can open a blackout window. Slips that arrive while the window is open are discarded. The window lasts `WIN` clock cycles, and a new key edge during the window starts it again at full length. In the alternative mode there is no blackout, and slips count only while an external lock-status input is high. After the flag drops it stays low until software sets the hold bit, which clears the counter.

Top module: `slip_unlock_det`

## Requirements
- R1: After reset, `cfg_rdata` reads 8'h00 and `lock_detect` is 1.
- R2: A write (`cfg_we`=1) at a clock edge stores `cfg_wdata[4:0]`. From the next cycle, `cfg_rdata` reads those five bits in positions 4:0 and zeros in bits 7:5, whatever was written to bits 7:5.
- R3: The limit-select field `cfg[1:0]`=n sets the limit to n+1 accepted slips. `lock_detect` goes low in the cycle after the edge that samples the accepted slip which brings the count to n+1, and not earlier.
- R4: While the hold bit `cfg[4]` is 1, every edge clears the slip counter and re-arms the flag. Slips are not counted, and `lock_detect` reads 1 from the cycle after the first edge with hold set.
- R5: Once `lock_detect` is low, it stays low until the hold bit is set. Raising the limit in `cfg[1:0]` does not bring it back high.
- R6: With the key-blackout bit `cfg[3]`=1 and `cfg[2]`=0, raise `key_in` before edge k. The two-flop synchronizer and the edge detector delay the event, so slips sampled at edges k+3 through k+2+`WIN` are ignored. Slips at other edges are counted.
- R7: A key rising edge detected while the window is open reloads the window to its full `WIN` cycles.
- R8: With the blackout-disable bit `cfg[2]`=1, no blackout applies. A slip is counted only if `lock_ok` is 1 at the same edge.
- R9: With `cfg[3]`=0 and `cfg[2]`=0, key edges open no window and every slip is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back |
| key_in | input | 1 | Asynchronous transmit-key input |
| lock_ok | input | 1 | Lock-status input that gates counting when blackout is disabled |
| slip_pulse | input | 1 | Cycle-slip pulse, one clock wide |
| lock_detect | output | 1 | High while locked, low after the slip limit is reached |

## Verification
Directed runs send trains of slips under each of the four limits. These show that the flag falls on exactly the right slip and no sooner. Key edges are placed against slip trains so that slips land just before the window, inside it and just after it, which checks the three-edge sync delay and the window length. A second key edge inside the window shows a restart and not an expiry. Runs with `lock_ok` toggled under blackout-disable separate gating by the status input from gating by the window. Constrained-random traffic then mixes configuration writes, key toggles and slips against a cycle model kept in the bench.

// File: rtl/slipdet_pkg.sv
package slipdet_pkg;

  typedef struct packed {
    logic [2:0] rsvd;
    logic       hold;
    logic       key_bo;
    logic       bo_off;
    logic [1:0] lim_sel;
  } det_cfg_t;

  // Number of accepted slips that declares unlock.
  function automatic int unsigned slip_limit(input logic [1:0] sel);
    return int'(sel) + 1;
  endfunction

  // Mask of bits that hold storage.
  function automatic logic [7:0] cfg_keep(input logic [7:0] d);
    return {3'b000, d[4:0]};
  endfunction

endpackage

// File: rtl/key_rise_sync.sv
module key_rise_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic key_async,
  output logic key_rise
);
  logic [2:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[1:0], key_async};
  end

  assign key_rise = stg[1] & ~stg[2];
endmodule

// File: rtl/blackout_timer.sv
module blackout_timer #(
  parameter int WIN   = 64,
  parameter int WIN_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_en,
  input  logic             trigger,
  output logic [WIN_W-1:0] win_left,
  output logic             win_open
);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                win_left <= '0;
    else if (arm_en && trigger) win_left <= WIN_LOAD;
    else if (win_left != '0)   win_left <= win_left - 1'b1;
  end

  assign win_open = (win_left != '0);
endmodule

// File: rtl/slip_counter.sv
module slip_counter
  import slipdet_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             slip_ok,
  input  logic [1:0]       lim_sel,
  output logic [CNT_W-1:0] slip_cnt,
  output logic             unlocked
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (clr)                                cnt_nxt = '0;
    else if (slip_ok && slip_cnt != CNT_MAX) cnt_nxt = slip_cnt + 1'b1;
    else                                    cnt_nxt = slip_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slip_cnt <= '0;
      unlocked <= 1'b0;
    end else begin
      slip_cnt <= cnt_nxt;
      unlocked <= clr ? 1'b0
                : (unlocked | (int'(cnt_nxt) >= int'(slip_limit(lim_sel))));
    end
  end
endmodule

// File: rtl/slip_unlock_det.sv
module slip_unlock_det
  import slipdet_pkg::*;
#(
  parameter int WIN   = 64,
  parameter int CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       key_in,
  input  logic       lock_ok,
  input  logic       slip_pulse,
  output logic       lock_detect
);
  localparam int WIN_W = $clog2(WIN + 1);

  det_cfg_t         cfg_q;
  logic             key_rise;
  logic [WIN_W-1:0] win_left;
  logic             win_open;
  logic             slip_ok;
  logic [CNT_W-1:0] slip_cnt;
  logic             unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= det_cfg_t'(cfg_keep(cfg_wdata));
  end

  assign cfg_rdata = cfg_q;

  key_rise_sync u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_async(key_in),
    .key_rise (key_rise)
  );

  blackout_timer #(.WIN(WIN), .WIN_W(WIN_W)) u_bo (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_en  (cfg_q.key_bo),
    .trigger (key_rise),
    .win_left(win_left),
    .win_open(win_open)
  );

  // Qualified slip: blackout-disable mode gates on lock_ok, otherwise on window.
  assign slip_ok = slip_pulse & ~cfg_q.hold &
                   (cfg_q.bo_off ? lock_ok : ~win_open);

  slip_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cfg_q.hold),
    .slip_ok (slip_ok),
    .lim_sel (cfg_q.lim_sel),
    .slip_cnt(slip_cnt),
    .unlocked(unlocked)
  );

  assign lock_detect = ~unlocked;
endmodule

// File: rtl/slipdet_chk.sv
module slipdet_chk
  import slipdet_pkg::*;
#(
  parameter int WIN   = 64,
  parameter int WIN_W = 7,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [7:0]       cfg_wdata,
  input logic [7:0]       cfg_rdata,
  input logic             lock_ok,
  input logic             lock_detect,
  input logic             key_rise,
  input logic             win_open,
  input logic [WIN_W-1:0] win_left,
  input logic             slip_ok,
  input logic [CNT_W-1:0] slip_cnt
);
  // R2: stored value tracks the low five written bits
  p_write_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == {3'b000, $past(cfg_wdata[4:0])});

  // R4: hold clears counter and raises the flag
  p_hold_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[4] |=> (slip_cnt == '0) && lock_detect);

  // R5: low flag persists without hold
  p_sticky_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_detect && !cfg_rdata[4]) |=> !lock_detect);

  // R3: reaching the limit drops the flag
  p_limit_unlock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[4] && int'(slip_cnt) >= int'(slip_limit(cfg_rdata[1:0])))
      |=> !lock_detect);

  // R6: open window masks slips
  p_window_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && !cfg_rdata[2]) |-> !slip_ok);

  // R7: armed key edge reloads the full window
  p_key_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_rise && cfg_rdata[3]) |=> int'(win_left) == WIN);

  // R8: blackout-disable gates on lock_ok
  p_status_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[2] && !lock_ok) |-> !slip_ok);

  // Counter never wraps to zero on a slip
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_ok && !cfg_rdata[4] && slip_cnt != '0) |=> slip_cnt != '0);
endmodule

bind slip_unlock_det slipdet_chk #(.WIN(WIN), .WIN_W(WIN_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .lock_ok    (lock_ok),
  .lock_detect(lock_detect),
  .key_rise   (key_rise),
  .win_open   (win_open),
  .win_left   (win_left),
  .slip_ok    (slip_ok),
  .slip_cnt   (slip_cnt)
);

// File: tb/slip_unlock_det_test.sv
`timescale 1ns/1ps
module slip_unlock_det_test;
  localparam int WIN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       key_in = 1'b0;
  logic       lock_ok = 1'b0;
  logic       slip_pulse = 1'b0;
  logic       lock_detect;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;
  string tag = "R1";

  // Bench reference state
  logic [7:0] m_cfg;
  bit m_s1, m_s2, m_s3, m_unl;
  int m_win, m_cnt;

  always #5 clk = ~clk;

  slip_unlock_det #(.WIN(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .key_in(key_in), .lock_ok(lock_ok),
    .slip_pulse(slip_pulse), .lock_detect(lock_detect)
  );

  function automatic int lim_of(input logic [7:0] c);
    return int'(c[1:0]) + 1;
  endfunction

  function automatic bit slip_taken(input logic [7:0] c, input int win,
                                    input bit lk, input bit sl);
    if (c[4] || !sl) return 0;
    return c[2] ? lk : (win == 0);
  endfunction

  task automatic check(input bit act_l, input bit exp_l,
                       input logic [7:0] act_r, input logic [7:0] exp_r);
    n_vec++;
    if (act_l !== exp_l || act_r !== exp_r) begin
      n_bad++;
      $display("FAIL %s: lock_detect=%0b cfg_rdata=%02h expected lock_detect=%0b cfg_rdata=%02h",
               tag, act_l, act_r, exp_l, exp_r);
    end
  endtask

  task automatic step(input bit we, input logic [7:0] wd, input bit key,
                      input bit lk, input bit sl);
    bit rise;
    cfg_we = we; cfg_wdata = wd; key_in = key; lock_ok = lk; slip_pulse = sl;
    rise = m_s2 && !m_s3;
    if (m_cfg[4]) m_cnt = 0;
    else if (slip_taken(m_cfg, m_win, lk, sl) && m_cnt < 7) m_cnt++;
    m_unl = m_cfg[4] ? 0 : (m_unl || m_cnt >= lim_of(m_cfg));
    if (m_cfg[3] && rise) m_win = WIN;
    else if (m_win > 0)   m_win--;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = key;
    if (we) m_cfg = {3'b000, wd[4:0]};
    @(posedge clk); #1;
    check(lock_detect, !m_unl, cfg_rdata, m_cfg);
  endtask

  task automatic wr(input logic [7:0] v);
    step(1, v, key_in, lock_ok, 0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, key_in, lock_ok, 0);
  endtask
  task automatic slip1();
    step(0, 0, key_in, lock_ok, 1);
  endtask
  task automatic rearm(input logic [7:0] v);
    wr(8'h10); wr(v);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_cfg = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_unl = 0; m_win = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tag = "R1"; check(lock_detect, 1'b1, cfg_rdata, 8'h00);

    tag = "R2"; wr(8'hFF); wr(8'hE0); wr(8'hA5); wr(8'h00);

    tag = "R9";  // no blackout: key edge ignored, first slip unlocks
    step(0, 0, 1, 0, 0); idle(3); slip1(); idle(2);
    step(0, 0, 0, 0, 0);

    tag = "R3";
    for (int s = 0; s < 4; s++) begin
      rearm(8'(s));
      for (int k = 0; k <= s; k++) begin slip1(); idle(2); end
    end

    tag = "R5"; rearm(8'h00); slip1(); wr(8'h03); idle(3);
    tag = "R4"; wr(8'h13);
    for (int k = 0; k < 6; k++) slip1();
    wr(8'h03); idle(2);

    tag = "R6"; rearm(8'h0B);
    step(0, 0, 1, 0, 0);
    for (int k = 0; k < WIN + 6; k++) slip1();
    step(0, 0, 0, 0, 0); idle(2);
    rearm(8'h09);
    step(0, 0, 1, 0, 0); slip1(); slip1(); slip1(); idle(WIN - 1); slip1(); idle(2);
    step(0, 0, 0, 0, 0);

    tag = "R7"; rearm(8'h08);
    step(0, 0, 1, 0, 0); idle(4);
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    for (int k = 0; k < WIN + 4; k++) begin slip1(); idle(1); end
    step(0, 0, 0, 0, 0);

    tag = "R8"; rearm(8'h0F);
    step(0, 0, 1, 0, 0); idle(2);
    for (int k = 0; k < 6; k++) step(0, 0, 1, 0, 1);
    step(0, 0, 1, 1, 1); step(0, 0, 1, 0, 1); step(0, 0, 1, 1, 1);
    step(0, 0, 1, 1, 1); step(0, 0, 1, 1, 1); idle(2);
    step(0, 0, 0, 0, 0);

    tag = "R3,R6,R8 random";
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < 4000; c++) begin
      bit we = ($urandom % 40) == 0;
      logic [7:0] wd = 8'($urandom);
      bit key = (($urandom % 9) == 0) ? !key_in : key_in;
      bit lk = ($urandom % 3) != 0;
      bit sl = ($urandom % 5) == 0;
      if (($urandom % 60) == 0) begin we = 1; wd[4] = 1; end
      step(we, wd, key, lk, sl);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule